// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI target that sits inside a logic device and takes 16-bit words from a host controller. Each word holds a 4-bit opcode in its upper nibble and a 12-bit argument below it. The serial clock idles low. Data is captured on the rising serial clock edge, and the host changes it on the falling edge. The host frames every word with its own chip-select pulse.

The serial clock, serial data and chip select are brought into the system clock domain through synchronisers. Edge detection and bit counting then run on the system clock. A word counts as accepted only when chip select returns high after exactly sixteen rising clock edges. An accepted word is stored in a register file entry selected by its opcode. It is also presented for one system clock cycle together with a valid strobe. One opcode selects the mode configuration register, and the low byte of that register drives a dedicated output.

Top module: `spi_cmd_rx`

## Requirements
- R1: After the synchronous active-high reset, `cmd_valid` is 0, every register file entry reads 0 through `rd_sel`/`rd_data`, and `mode_cfg` is 0.
- R2: A frame is sent most significant bit first. Bit 15 is the first bit captured. Bits 15..12 appear on `cmd_code` and bits 11..0 appear on `cmd_data` while `cmd_valid` is high.
- R3: Each accepted word raises `cmd_valid` for exactly one system clock cycle, within 12 system clock cycles after `spi_cs_n` rises.
- R4: An accepted word writes its 12-bit argument into the register file entry indexed by its opcode. No other entry changes. `rd_data` returns the entry selected by `rd_sel`.
- R5: Opcode value `MODE_CMD` (default 4'h1) selects the mode configuration register. `mode_cfg` equals bits 7..0 of that entry, one cycle after the write.
- R6: If chip select rises after fewer than 16 rising serial clock edges, the frame is discarded. No strobe is raised and no entry changes.
- R7: If more than 16 rising serial clock edges arrive within one chip-select window, the frame is discarded. No strobe is raised and no entry changes.
- R8: Serial clock activity while `spi_cs_n` is high is ignored. It produces no strobe and does not disturb the next frame.
- R9: Frames are decoded correctly with the system clock at 4 times the serial clock rate, as well as at slower serial clock rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low frame select |
| rd_sel | input | 4 | Register file read index |
| rd_data | output | 12 | Contents of the selected register file entry |
| cmd_valid | output | 1 | One-cycle strobe for an accepted word |
| cmd_code | output | 4 | Opcode of the accepted word |
| cmd_data | output | 12 | Argument of the accepted word |
| mode_cfg | output | 8 | Low byte of the mode configuration register |

## Verification
A wrong bit count or a misaligned shift register shows up at the ports as a missing strobe, an extra strobe or a rotated opcode/argument. The strobe and its fields are checked within 12 cycles of each chip-select release, and the addressed entry is read back right after. Discarded frames are checked by confirming that no strobe appears and that both the addressed entry and `mode_cfg` still hold their earlier values. A corrupted register file entry is seen at the next read of that index, and a corrupted mode entry is seen on `mode_cfg` one cycle after the write.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

    localparam int CMD_W   = 4;
    localparam int DATA_W  = 12;
    localparam int WORD_W  = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int RF_DEPTH = 1 << CMD_W;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [DATA_W-1:0] arg;
    } cmd_word_t;

    // Saturating increment: stops one past a full word to flag overrun
    function automatic logic [CNT_W-1:0] bump_count(input logic [CNT_W-1:0] c);
        if (c == CNT_W'(WORD_W + 1))
            return c;
        return c + CNT_W'(1);
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
    parameter int          NSIG    = 3,
    parameter int          STAGES  = 2,
    parameter logic [NSIG-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] din,
    output logic [NSIG-1:0] level,
    output logic [NSIG-1:0] rise,
    output logic [NSIG-1:0] fall
);

    generate
        for (genvar g = 0; g < NSIG; g++) begin : g_sig
            logic [STAGES:0] chain;

            always_ff @(posedge clk) begin
                if (rst)
                    chain <= {(STAGES+1){RST_VAL[g]}};
                else
                    chain <= {chain[STAGES-1:0], din[g]};
            end

            assign level[g] = chain[STAGES-1];
            assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
            assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/spi_word_framer.sv
`timescale 1ns/1ps
module spi_word_framer
    import spi_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_rise,
    input  logic      mosi_lvl,
    input  logic      sel_lvl_n,
    input  logic      sel_end,
    output logic      word_ok,
    output cmd_word_t word_q
);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            nbits   <= '0;
            word_ok <= 1'b0;
            word_q  <= '0;
        end else begin
            word_ok <= 1'b0;
            if (!sel_lvl_n) begin
                if (sclk_rise) begin
                    shreg <= {shreg[WORD_W-2:0], mosi_lvl};
                    nbits <= bump_count(nbits);
                end
            end else begin
                nbits <= '0;
            end
            if (sel_end && nbits == CNT_W'(WORD_W)) begin
                word_ok <= 1'b1;
                word_q  <= cmd_word_t'(shreg);
            end
        end
    end

endmodule

// File: rtl/cmd_regfile.sv
`timescale 1ns/1ps
module cmd_regfile
    import spi_cmd_pkg::*;
#(
    parameter int MODE_CMD = 1,
    parameter int MODE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cmd_word_t         wr_word,
    input  logic [CMD_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [MODE_W-1:0] mode_cfg
);

    logic [DATA_W-1:0] regs [RF_DEPTH];

    generate
        for (genvar e = 0; e < RF_DEPTH; e++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst)
                    regs[e] <= '0;
                else if (wr_en && wr_word.op == CMD_W'(e))
                    regs[e] <= wr_word.arg;
            end
        end
    endgenerate

    assign rd_data  = regs[rd_sel];
    assign mode_cfg = regs[MODE_CMD][MODE_W-1:0];

endmodule

// File: rtl/spi_cmd_rx.sv
`timescale 1ns/1ps
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter int MODE_CMD    = 1,
    parameter int MODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    input  logic [3:0]        rd_sel,
    output logic [11:0]       rd_data,
    output logic              cmd_valid,
    output logic [3:0]        cmd_code,
    output logic [11:0]       cmd_data,
    output logic [7:0]        mode_cfg
);

    localparam int IX_SCLK = 0;
    localparam int IX_MOSI = 1;
    localparam int IX_SEL  = 2;

    logic [2:0] s_lvl, s_rise, s_fall;
    logic       frm_ok;
    cmd_word_t  frm_word;

    spi_in_sync #(
        .NSIG    (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({spi_cs_n, spi_mosi, spi_sclk}),
        .level (s_lvl),
        .rise  (s_rise),
        .fall  (s_fall)
    );

    spi_word_framer u_frm (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (s_rise[IX_SCLK]),
        .mosi_lvl  (s_lvl[IX_MOSI]),
        .sel_lvl_n (s_lvl[IX_SEL]),
        .sel_end   (s_rise[IX_SEL]),
        .word_ok   (frm_ok),
        .word_q    (frm_word)
    );

    cmd_regfile #(
        .MODE_CMD (MODE_CMD),
        .MODE_W   (MODE_W)
    ) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (frm_ok),
        .wr_word  (frm_word),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .mode_cfg (mode_cfg)
    );

    assign cmd_valid = frm_ok;
    assign cmd_code  = frm_word.op;
    assign cmd_data  = frm_word.arg;

    logic unused_fall;
    assign unused_fall = ^s_fall;

endmodule

// File: rtl/spi_cmd_rx_chk.sv
`timescale 1ns/1ps
module spi_cmd_rx_chk #(
    parameter int MODE_CMD = 1,
    parameter int MODE_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [3:0]        cmd_code,
    input logic [11:0]       cmd_data,
    input logic [MODE_W-1:0] mode_cfg
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!cmd_valid && mode_cfg == '0));

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R2
    fields_known_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$isunknown({cmd_code, cmd_data}));

    // R5
    mode_update_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'(MODE_CMD)) |=> mode_cfg == $past(cmd_data[MODE_W-1:0]));

    // R6
    mode_only_by_word_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_cfg) |-> $past(cmd_valid));

endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
    .MODE_CMD (MODE_CMD),
    .MODE_W   (MODE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .mode_cfg  (mode_cfg)
);

// File: tb/sim_spi_cmd_rx.sv
`timescale 1ns/1ps
module sim_spi_cmd_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic [3:0]  rd_sel = '0;
    logic [11:0] rd_data;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [11:0] cmd_data;
    logic [7:0]  mode_cfg;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spi_cmd_rx u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .rd_sel(rd_sel), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .mode_cfg(mode_cfg)
    );

    // stimulus table: {bit count, word}
    typedef struct packed {
        logic [4:0]  nbits;
        logic [15:0] word;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{5'd16, 16'h1FA5},
        '{5'd16, 16'h3123},
        '{5'd16, 16'hFFFF},
        '{5'd16, 16'h0801},
        '{5'd9,  16'h7777},
        '{5'd17, 16'h3456},
        '{5'd16, 16'h13C0},
        '{5'd15, 16'h1FFF},
        '{5'd16, 16'hA5A5}
    };

    logic [11:0] model [16];
    int          n_pulse;
    logic [3:0]  got_code;
    logic [11:0] got_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // send nbits of word MSB first; bits past 16 are zero
    task automatic send_frame(input int nbits, input logic [15:0] w, input int half);
        n_pulse = 0;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(half);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(half);
            @(negedge clk);
            sclk = 1'b1;
            wait_clk(half);
        end
        @(negedge clk);
        sclk = 1'b0;
        wait_clk(half);
        @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #1;
            if (cmd_valid) begin
                n_pulse++;
                got_code = cmd_code;
                got_data = cmd_data;
            end
        end
    endtask

    task automatic read_entry(input logic [3:0] idx, output logic [11:0] val);
        @(negedge clk);
        rd_sel = idx;
        #1;
        val = rd_data;
    endtask

    task automatic apply(input int nbits, input logic [15:0] w, input int half, input string tag);
        logic [11:0] rv;
        logic        commit;
        commit = (nbits == 16);
        send_frame(nbits, w, half);
        chk({tag, " strobe count"}, n_pulse, commit ? 1 : 0);
        if (commit) begin
            model[w[15:12]] = w[11:0];
            chk({tag, " R2 opcode"}, got_code, w[15:12]);
            chk({tag, " R2 argument"}, got_data, w[11:0]);
        end
        read_entry(w[15:12], rv);
        chk({tag, " R4 entry"}, rv, model[w[15:12]]);
        chk({tag, " R5 mode_cfg"}, mode_cfg, model[1][7:0]);
    endtask

    initial begin
        logic [11:0] rv;
        for (int i = 0; i < 16; i++) model[i] = '0;
        wait_clk(4);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 mode_cfg", mode_cfg, 0);
        for (int i = 0; i < 16; i++) begin
            read_entry(4'(i), rv);
            chk("R1 entry", rv, 0);
        end

        // table walk: R2 R3 R4 R5 R6 R7 at half period 4 clocks
        for (int v = 0; v < NVEC; v++) begin
            string t;
            if (VECS[v].nbits < 16)      t = "R6";
            else if (VECS[v].nbits > 16) t = "R7";
            else                         t = "R3";
            apply(int'(VECS[v].nbits), VECS[v].word, 4, t);
        end

        // R8: serial clock toggles with chip select high
        n_pulse = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); sclk = 1'b1; mosi = 1'b1;
            wait_clk(3);
            @(negedge clk); sclk = 1'b0;
            wait_clk(3);
        end
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1;
            if (cmd_valid) n_pulse++;
        end
        chk("R8 idle toggles strobe", n_pulse, 0);
        read_entry(4'hF, rv);
        chk("R8 idle toggles entry", rv, model[15]);
        apply(16, 16'h6B2D, 4, "R8");

        // R9 fastest rate: system clock 4x serial clock
        apply(16, 16'h1E17, 2, "R9");
        apply(16, 16'hC3F0, 2, "R9");
        apply(12, 16'hC000, 2, "R9 R6");

        // R4: untouched entries still zero
        read_entry(4'h2, rv);
        chk("R4 untouched", rv, 0);

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        wait_clk(2);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 mode after reset", mode_cfg, 0);
        read_entry(4'hC, rv);
        chk("R1 entry after reset", rv, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
                $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

endmodule